// File: doc/BRIEF.md
# Multi-Source Trigger Selector with Pattern Latch

This block merges several asynchronous detector trigger lines into one trigger decision inside a single clock domain. Each line is resampled by a two-stage synchronizer and reduced to a one-cycle pulse per rising edge, so every edge is placed on a clock boundary with up to one clock period of jitter. Each line then feeds a singles path with its own downscale factor. A pair of selectable lines feeds a coincidence detector with a programmable window. A per-source enable mask chooses which singles, and whether the coincidence term, drive the raw trigger. Several sources can be enabled at once, so one physical event can give more than one raw pulse.

A raw trigger that occurs while the block is idle becomes a live trigger. The block then latches a bit pattern of the contributing sources, captures a free-running 48-bit cycle timestamp in the same cycle, and raises busy. A valid/ready read port presents the pattern word and then the low 32 bits of the timestamp. Busy is released only after both words are accepted. A free-running event counter on every input records true input rates, independent of enables, downscaling and busy.

The readout sequencer has three states. `ST_IDLE` moves to `ST_WORD0` on a raw trigger. `ST_WORD0` moves to `ST_WORD1` when the pattern word is accepted. `ST_WORD1` returns to `ST_IDLE` when the timestamp word is accepted. Each state holds while `rd_ready` is low.

Top module: `trig_select`

## Requirements
- R1: A rising edge on `trig_in[i]` that is first sampled at clock edge k causes `raw_trig`/`live_trig` to go high after clock edge k+2 for exactly one cycle, even if the input stays high.
- R2: The singles path of input i passes the N-th, 2N-th, ... edge counted from reset, where N is `ds_factor[i*DS_W +: DS_W]`. N equal to 0 or 1 passes every edge.
- R3: The coincidence term fires in the cycle of the later edge when the edge pulses of inputs `coinc_sel_a` and `coinc_sel_b` are at most W cycles apart (W = `coinc_win`), in either order. W = 0 requires the same cycle.
- R4: `raw_trig` is the registered OR of the passed singles enabled in `single_en` and the coincidence term gated by `coinc_en`. It pulses once per contributing cycle, so singles and coincidence can give two pulses for one event.
- R5: A raw trigger while busy is low gives a one-cycle `live_trig` and raises `busy` in the same cycle. A raw trigger while busy is high gives no live trigger and leaves the latched pattern unchanged.
- R6: The pattern word holds the enabled passed singles in bits [NUM_IN-1:0] and the enabled coincidence term in bit NUM_IN. All higher bits are zero.
- R7: `rd_valid` equals `busy`. The pattern word is presented first with `rd_last`=0. After it is accepted (`rd_valid`&`rd_ready` at a clock edge), the timestamp word is presented with `rd_last`=1. After that word is accepted, busy and valid fall. The data is held while `rd_ready` is low.
- R8: The timestamp counter is 0 in the first cycle after reset and adds 1 each clock. The second word is the low 32 bits of the count in the cycle the pattern was latched.
- R9: `evt_cnt[i*CNT_W +: CNT_W]` counts every rising edge of input i, regardless of enables, downscaling or busy, and wraps.
- R10: After reset, `raw_trig`, `live_trig`, `busy`, `rd_valid` are low and all event counters are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_in | input | NUM_IN | Asynchronous trigger lines |
| single_en | input | NUM_IN | Enable mask for singles paths |
| coinc_en | input | 1 | Enable for the coincidence term |
| ds_factor | input | NUM_IN*DS_W | Per-input downscale factor, packed |
| coinc_sel_a | input | SEL_W | First coincidence input index |
| coinc_sel_b | input | SEL_W | Second coincidence input index |
| coinc_win | input | WIN_W | Coincidence window in cycles |
| raw_trig | output | 1 | Raw trigger pulse |
| live_trig | output | 1 | Live trigger pulse |
| busy | output | 1 | Event held, awaiting readout |
| rd_valid | output | 1 | Read word valid |
| rd_ready | input | 1 | Read word accepted |
| rd_data | output | 32 | Pattern word, then timestamp word |
| rd_last | output | 1 | High on the timestamp word |
| evt_cnt | output | NUM_IN*CNT_W | Per-input edge counters, packed |

## Verification
On every cycle the assertions check several properties. A live trigger comes only with a raw trigger and only from a non-busy state. Valid tracks busy, and read data holds while stalled. The timestamp and the input 0 counter advance by the allowed steps. The bench's sweeps show the arithmetic behaviours that no single-cycle property can capture: the pass ratio for each downscale factor, the boundary of the coincidence window in both orders, the double raw pulse from one event, the two-stage latency, and the exact pattern and timestamp values in readout order.

// File: rtl/trig_pkg.sv
package trig_pkg;
    localparam int WORD_W = 32;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WORD0 = 2'd1,
        ST_WORD1 = 2'd2
    } rd_state_t;
endpackage

// File: rtl/trig_sync_edge.sv
module trig_sync_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic pulse
);
    logic meta_q, sync_q, prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= async_in;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign pulse = sync_q & ~prev_q;
endmodule

// File: rtl/trig_downscale.sv
module trig_downscale #(
    parameter int DS_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pulse_in,
    input  logic [DS_W-1:0] factor,
    output logic            pulse_out
);
    logic [DS_W-1:0] cnt_q;
    logic            bypass;

    assign bypass    = (factor <= DS_W'(1));
    assign pulse_out = pulse_in && (bypass || (cnt_q == factor - DS_W'(1)));

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (pulse_in)
            cnt_q <= pulse_out ? '0 : cnt_q + DS_W'(1);
    end
endmodule

// File: rtl/trig_coinc.sv
module trig_coinc #(
    parameter int WIN_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pulse_a,
    input  logic             pulse_b,
    input  logic [WIN_W-1:0] window,
    output logic             hit
);
    logic [WIN_W-1:0] tmr_a_q, tmr_b_q;

    assign hit = (pulse_a && (pulse_b || tmr_b_q != '0)) ||
                 (pulse_b && tmr_a_q != '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr_a_q <= '0;
            tmr_b_q <= '0;
        end else begin
            if (pulse_a)
                tmr_a_q <= window;
            else if (tmr_a_q != '0)
                tmr_a_q <= tmr_a_q - WIN_W'(1);
            if (pulse_b)
                tmr_b_q <= window;
            else if (tmr_b_q != '0)
                tmr_b_q <= tmr_b_q - WIN_W'(1);
        end
    end
endmodule

// File: rtl/trig_select.sv
module trig_select
    import trig_pkg::*;
#(
    parameter  int NUM_IN = 4,
    parameter  int DS_W   = 4,
    parameter  int WIN_W  = 4,
    parameter  int CNT_W  = 16,
    parameter  int TS_W   = 48,
    localparam int SEL_W  = (NUM_IN > 1) ? $clog2(NUM_IN) : 1,
    localparam int PAT_W  = NUM_IN + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_IN-1:0]       trig_in,
    input  logic [NUM_IN-1:0]       single_en,
    input  logic                    coinc_en,
    input  logic [NUM_IN*DS_W-1:0]  ds_factor,
    input  logic [SEL_W-1:0]        coinc_sel_a,
    input  logic [SEL_W-1:0]        coinc_sel_b,
    input  logic [WIN_W-1:0]        coinc_win,
    output logic                    raw_trig,
    output logic                    live_trig,
    output logic                    busy,
    output logic                    rd_valid,
    input  logic                    rd_ready,
    output logic [WORD_W-1:0]       rd_data,
    output logic                    rd_last,
    output logic [NUM_IN*CNT_W-1:0] evt_cnt
);
    logic [NUM_IN-1:0] edge_p;
    logic [NUM_IN-1:0] single_p;
    logic              coinc_hit;
    logic [PAT_W-1:0]  hit_vec;
    logic              raw_now;

    rd_state_t         state_q, state_d;
    logic [PAT_W-1:0]  pat_q;
    logic [WORD_W-1:0] ts_lat_q;
    logic [TS_W-1:0]   ts_cnt;
    logic              raw_q, live_q;

    for (genvar i = 0; i < NUM_IN; i++) begin : g_in
        trig_sync_edge u_sync (
            .clk      (clk),
            .rst_n    (rst_n),
            .async_in (trig_in[i]),
            .pulse    (edge_p[i])
        );

        trig_downscale #(.DS_W(DS_W)) u_ds (
            .clk       (clk),
            .rst_n     (rst_n),
            .pulse_in  (edge_p[i]),
            .factor    (ds_factor[i*DS_W +: DS_W]),
            .pulse_out (single_p[i])
        );

        logic [CNT_W-1:0] cnt_q;
        always_ff @(posedge clk) begin
            if (!rst_n)
                cnt_q <= '0;
            else if (edge_p[i])
                cnt_q <= cnt_q + CNT_W'(1);
        end
        assign evt_cnt[i*CNT_W +: CNT_W] = cnt_q;
    end

    trig_coinc #(.WIN_W(WIN_W)) u_coinc (
        .clk     (clk),
        .rst_n   (rst_n),
        .pulse_a (edge_p[coinc_sel_a]),
        .pulse_b (edge_p[coinc_sel_b]),
        .window  (coinc_win),
        .hit     (coinc_hit)
    );

    assign hit_vec = {coinc_hit & coinc_en, single_p & single_en};
    assign raw_now = |hit_vec;

    always_ff @(posedge clk) begin
        if (!rst_n)
            ts_cnt <= '0;
        else
            ts_cnt <= ts_cnt + TS_W'(1);
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (raw_now)  state_d = ST_WORD0;
            ST_WORD0: if (rd_ready) state_d = ST_WORD1;
            ST_WORD1: if (rd_ready) state_d = ST_IDLE;
            default:                state_d = ST_IDLE;
        endcase
    end

    // state register and event capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            pat_q    <= '0;
            ts_lat_q <= '0;
            raw_q    <= 1'b0;
            live_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            raw_q   <= raw_now;
            live_q  <= raw_now && (state_q == ST_IDLE);
            if (raw_now && state_q == ST_IDLE) begin
                pat_q    <= hit_vec;
                ts_lat_q <= ts_cnt[WORD_W-1:0];
            end
        end
    end

    // outputs
    always_comb begin
        raw_trig  = raw_q;
        live_trig = live_q;
        busy      = 1'b1;
        rd_valid  = 1'b1;
        rd_last   = 1'b0;
        rd_data   = WORD_W'(pat_q);
        unique case (state_q)
            ST_IDLE: begin
                busy     = 1'b0;
                rd_valid = 1'b0;
            end
            ST_WORD0: ;
            ST_WORD1: begin
                rd_last = 1'b1;
                rd_data = ts_lat_q;
            end
            default: begin
                busy     = 1'b0;
                rd_valid = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/trig_select_chk.sv
module trig_select_chk #(
    parameter int NUM_IN = 4,
    parameter int CNT_W  = 16,
    parameter int TS_W   = 48
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    raw_trig,
    input logic                    live_trig,
    input logic                    busy,
    input logic                    rd_valid,
    input logic                    rd_ready,
    input logic [31:0]             rd_data,
    input logic [NUM_IN*CNT_W-1:0] evt_cnt,
    input logic [TS_W-1:0]         ts_cnt
);
    assert_live_has_raw_R5: assert property (@(posedge clk) disable iff (!rst_n)
        live_trig |-> raw_trig);

    assert_live_sets_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        live_trig |-> busy);

    assert_live_from_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        live_trig |-> !$past(busy));

    assert_valid_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid == busy);

    assert_hold_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

    assert_pattern_nonzero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        live_trig |-> (rd_data != 32'd0));

    assert_ts_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (ts_cnt == TS_W'($past(ts_cnt) + TS_W'(1))));

    assert_cnt_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((evt_cnt[CNT_W-1:0] == $past(evt_cnt[CNT_W-1:0])) ||
                          (evt_cnt[CNT_W-1:0] == CNT_W'($past(evt_cnt[CNT_W-1:0]) + CNT_W'(1)))));
endmodule

bind trig_select trig_select_chk #(
    .NUM_IN (NUM_IN),
    .CNT_W  (CNT_W),
    .TS_W   (TS_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .raw_trig  (raw_trig),
    .live_trig (live_trig),
    .busy      (busy),
    .rd_valid  (rd_valid),
    .rd_ready  (rd_ready),
    .rd_data   (rd_data),
    .evt_cnt   (evt_cnt),
    .ts_cnt    (ts_cnt)
);

// File: tb/tb_trig_select.sv
`timescale 1ns/1ps
module tb_trig_select;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  trig_in = '0;
    logic [3:0]  single_en = '0;
    logic        coinc_en = 1'b0;
    logic [15:0] ds_factor = '0;
    logic [1:0]  coinc_sel_a = 2'd0;
    logic [1:0]  coinc_sel_b = 2'd1;
    logic [3:0]  coinc_win = 4'd3;
    logic        raw_trig, live_trig, busy, rd_valid, rd_last;
    logic        rd_ready = 1'b1;
    logic [31:0] rd_data;
    logic [63:0] evt_cnt;

    trig_select dut (
        .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .single_en(single_en),
        .coinc_en(coinc_en), .ds_factor(ds_factor), .coinc_sel_a(coinc_sel_a),
        .coinc_sel_b(coinc_sel_b), .coinc_win(coinc_win), .raw_trig(raw_trig),
        .live_trig(live_trig), .busy(busy), .rd_valid(rd_valid), .rd_ready(rd_ready),
        .rd_data(rd_data), .rd_last(rd_last), .evt_cnt(evt_cnt)
    );

    always #5 clk = ~clk;

    int          n_chk = 0, n_fail = 0;
    int          raw_n = 0, live_n = 0;
    logic [31:0] last_pat = '0;
    longint      last_ts = 0;
    longint      cyc = 0;

    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    always @(negedge clk) begin
        if (raw_trig) raw_n++;
        if (live_trig) begin
            live_n++;
            last_pat = rd_data;
            last_ts  = cyc - 1;
        end
    end

    task automatic check(input string tag, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk) rst_n = 1'b0;
        trig_in = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic fire(input logic [3:0] m);
        @(negedge clk) trig_in = trig_in | m;
        repeat (3) @(negedge clk);
        trig_in = trig_in & ~m;
        repeat (6) @(negedge clk);
    endtask

    task automatic pair(input int d, input logic [3:0] first, input logic [3:0] second);
        @(negedge clk) trig_in = trig_in | first;
        repeat (d) @(negedge clk);
        trig_in = trig_in | second;
        repeat (3) @(negedge clk);
        trig_in = '0;
        repeat (10) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int base_l, base_r;
        do_reset();
        // R10 reset state
        check("R10 raw", raw_trig, 0);
        check("R10 live", live_trig, 0);
        check("R10 busy", busy, 0);
        check("R10 valid", rd_valid, 0);
        check("R10 counters", evt_cnt, 0);

        // R1 latency and one pulse per edge
        single_en = 4'b0001; ds_factor = 16'h1111;
        @(negedge clk) trig_in = 4'b0001;
        @(negedge clk) check("R1 raw after 1 edge", raw_trig, 0);
        @(negedge clk) check("R1 raw after 2 edges", raw_trig, 0);
        @(negedge clk) check("R1 raw after 3 edges", raw_trig, 1);
        check("R1 live after 3 edges", live_trig, 1);
        @(negedge clk) check("R1 single pulse", raw_trig, 0);
        repeat (4) @(negedge clk);
        check("R1 no repeat while high", raw_n, 1);
        trig_in = '0;
        repeat (4) @(negedge clk);

        // R2 downscale sweep, factor 0..5
        for (int n = 0; n < 6; n++) begin
            do_reset();
            single_en = 4'b0001; coinc_en = 1'b0;
            ds_factor = {12'h000, 4'(n)};
            base_l = live_n; base_r = raw_n;
            for (int k = 0; k < 12; k++) fire(4'b0001);
            check($sformatf("R2 live N=%0d", n), live_n - base_l, (n <= 1) ? 12 : 12 / n);
            check($sformatf("R4 raw N=%0d", n), raw_n - base_r, (n <= 1) ? 12 : 12 / n);
            check($sformatf("R9 count N=%0d", n), evt_cnt[15:0], 12);
        end

        // R3 coincidence window sweep, both orders
        do_reset();
        single_en = 4'b0000; coinc_en = 1'b1; ds_factor = 16'h1111;
        coinc_sel_a = 2'd0; coinc_sel_b = 2'd1; coinc_win = 4'd3;
        for (int d = 0; d < 7; d++) begin
            for (int o = 0; o < 2; o++) begin
                base_l = live_n;
                if (o == 0) pair(d, 4'b0001, 4'b0010);
                else        pair(d, 4'b0010, 4'b0001);
                check($sformatf("R3 W=3 d=%0d order=%0d", d, o), live_n - base_l, (d <= 3) ? 1 : 0);
            end
        end
        check("R6 coincidence pattern", last_pat, 32'h10);
        coinc_win = 4'd0;
        base_l = live_n; pair(0, 4'b0001, 4'b0010);
        check("R3 W=0 d=0", live_n - base_l, 1);
        base_l = live_n; pair(1, 4'b0001, 4'b0010);
        check("R3 W=0 d=1", live_n - base_l, 0);

        // R4 singles plus coincidence: two raw pulses, one live
        do_reset();
        single_en = 4'b0001; coinc_en = 1'b1; coinc_win = 4'd3;
        base_l = live_n; base_r = raw_n;
        pair(2, 4'b0001, 4'b0010);
        check("R4 double raw", raw_n - base_r, 2);
        check("R5 single live for double raw", live_n - base_l, 1);
        check("R6 first pulse pattern", last_pat, 32'h1);

        // R6 disabled single excluded
        coinc_en = 1'b0; single_en = 4'b0101;
        fire(4'b0111);
        check("R6 enabled-only pattern", last_pat, 32'h5);

        // R5/R7/R8 stalled readout
        do_reset();
        single_en = 4'b1111; rd_ready = 1'b0;
        base_l = live_n;
        fire(4'b0101);
        check("R7 valid after live", rd_valid, 1);
        check("R7 first word flag", rd_last, 0);
        check("R7 first word pattern", rd_data, 32'h5);
        fire(4'b0010);
        check("R5 no live while busy", live_n - base_l, 1);
        check("R5 pattern unchanged", rd_data, 32'h5);
        check("R9 counted while busy", evt_cnt[31:16], 1);
        @(negedge clk) rd_ready = 1'b1;
        @(negedge clk);
        check("R7 second word flag", rd_last, 1);
        check("R8 timestamp word", rd_data, last_ts & 64'hFFFF_FFFF);
        check("R7 still busy on word 1", busy, 1);
        @(negedge clk);
        check("R7 busy released", busy, 0);
        check("R7 valid released", rd_valid, 0);
        check("R9 counter input 0", evt_cnt[15:0], 1);
        check("R9 counter input 2", evt_cnt[47:32], 1);
        check("R9 counter input 3", evt_cnt[63:48], 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule